// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block is the digital counter chain that sits behind a dual-modulus prescaler in the feedback path of a fractional-N synthesizer. It runs on the prescaler's output pulses, and it drives the prescaler's modulus-select line: high selects divide-by-(P+1) and low selects divide-by-P. It emits one output pulse per division cycle. P is fixed at elaboration to 32 (high-frequency variant) or 16 (low-frequency variant).

Each output cycle counts M prescaler pulses. The first A pulses of the cycle, plus one more when the fractional accumulator carries, use the P+1 modulus, and the remaining pulses use P. A single cycle therefore spans P*M + A + c input periods, where c is 0 or 1. The accumulator adds the 5-bit numerator F once per cycle, modulo 32, so over time the average ratio is P*M + A + F/32. An even F is run in reduced form: 12/32 uses a 3-of-8 accumulator. This gives denominators of 2, 4, 8, 16 or 32 with the same carry pattern as the full modulo-32 sum. The control word is M (9 bits) plus A (log2 P bits) plus F (5 bits), which is 19 bits for P=32 and 18 bits for P=16.

Top module: `fnd_divider_ctrl`

## Requirements
- R1: While reset is held, and in the first prescaler clock after it, `div_out` is 1 and `mod_sel` is 0. The first cycle after reset is one prescaler pulse long and divides by P.
- R2: Each output cycle contains exactly M prescaler clocks, using the M that was loaded at its start. `div_out` is high only on the last of them, so it is one prescaler clock wide when M>1.
- R3: Within a cycle, `mod_sel` is high on the first A+c prescaler clocks and low on the rest. It never rises except on the first clock of a cycle.
- R4: The length of a cycle, in prescaler input periods, is P*M + A + c.
- R5: The carry c of a cycle equals the carry out of adding F to a modulo-32 accumulator. The accumulator's reduced-denominator form yields the same carry sequence.
- R6: With F held constant, any 32 consecutive accumulating cycles after a clear contain exactly F carries.
- R7: M, A and F are sampled only at the last prescaler clock of a cycle. A change made in the middle of a cycle does not alter that cycle.
- R8: When the F loaded at a cycle boundary is zero, or differs from the F active in the previous cycle, the accumulator clears and that cycle has c=0.
- R9: `cfg_err` is 1 when A>M, when A=M with F not zero, or when M=0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output pulses, used as the clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_val | input | 9 | Main count M |
| a_val | input | log2(P) | Swallow count A |
| f_val | input | 5 | Fraction numerator F (over 32) |
| mod_sel | output | 1 | 1 selects divide-by-(P+1), 0 selects divide-by-P |
| div_out | output | 1 | Output pulse on the last prescaler clock of a cycle |
| cfg_err | output | 1 | Current inputs form an illegal configuration |

## Verification
The assertions assume that every configuration loaded at a cycle boundary is legal: M at least 1 and A+c no greater than M. Only then does the swallow phase fit within the M count. The random stimulus draws M from 2 to 20 and A below M, so any F is legal with them. Illegal combinations are driven only while reset is held, where they can be checked at `cfg_err` without ever being loaded. The directed cases add M=1, the legal edge A=M with F=0, F=31, and even values of F.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int FRAC_W = 5;

  // trailing zero count of a nonzero numerator (0 for zero)
  function automatic logic [2:0] frac_shift(input logic [FRAC_W-1:0] f);
    logic [2:0] s;
    s = 3'd0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (f[i]) s = 3'(i);
    end
    return s;
  endfunction

  // reduced numerator
  function automatic logic [FRAC_W-1:0] frac_num(input logic [FRAC_W-1:0] f);
    return f >> frac_shift(f);
  endfunction

  // reduced denominator: 32 >> shift
  function automatic logic [FRAC_W:0] frac_den(input logic [FRAC_W-1:0] f);
    return (FRAC_W+1)'(1 << FRAC_W) >> frac_shift(f);
  endfunction
endpackage

// File: rtl/fnd_accum.sv
module fnd_accum
  import fnd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [FRAC_W-1:0] f_new,
  output logic              carry
);
  logic [FRAC_W-1:0] f_r;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;
  logic [FRAC_W:0]   den;
  logic              restart;

  assign restart = (f_new == '0) || (f_new != f_r);
  assign sum     = {1'b0, acc} + {1'b0, frac_num(f_r)};
  assign den     = frac_den(f_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_r   <= '0;
      acc   <= '0;
      carry <= 1'b0;
    end else if (step) begin
      f_r <= f_new;
      if (restart) begin
        acc   <= '0;
        carry <= 1'b0;
      end else if (sum >= den) begin
        acc   <= FRAC_W'(sum - den);
        carry <= 1'b1;
      end else begin
        acc   <= FRAC_W'(sum);
        carry <= 1'b0;
      end
    end
  end

  assert_acc_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (f_r != '0) |-> ({1'b0, acc} < frac_den(f_r)));

  assert_clear_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ((f_new == '0) || (f_new != f_r))) |=> (acc == '0 && !carry));
endmodule

// File: rtl/fnd_swallow.sv
module fnd_swallow #(
  parameter int M_W = 9,
  parameter int A_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           carry,
  output logic           mod_sel,
  output logic           boundary
);
  logic [M_W-1:0] cnt;
  logic [M_W-1:0] m_r;
  logic [A_W-1:0] a_r;
  logic [M_W:0]   a_eff;

  assign boundary = (cnt == m_r - 1'b1);
  assign a_eff    = (M_W+1)'(a_r) + (M_W+1)'(carry);
  assign mod_sel  = ({1'b0, cnt} < a_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      m_r <= M_W'(1);
      a_r <= '0;
    end else if (boundary) begin
      cnt <= '0;
      m_r <= m_in;
      a_r <= a_in;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_sel_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_sel) |-> $past(boundary));

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_r != '0) |-> (cnt < m_r));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt == '0));
endmodule

// File: rtl/fnd_divider_ctrl.sv
module fnd_divider_ctrl
  import fnd_pkg::*;
#(
  parameter int PRE_MOD = 32,
  parameter int M_W     = 9,
  localparam int A_W    = $clog2(PRE_MOD)
) (
  input  logic              clk_pre,
  input  logic              rst_n,
  input  logic [M_W-1:0]    m_val,
  input  logic [A_W-1:0]    a_val,
  input  logic [FRAC_W-1:0] f_val,
  output logic              mod_sel,
  output logic              div_out,
  output logic              cfg_err
);
  logic cyc_end;
  logic frac_carry;

  fnd_accum u_accum (
    .clk   (clk_pre),
    .rst_n (rst_n),
    .step  (cyc_end),
    .f_new (f_val),
    .carry (frac_carry)
  );

  fnd_swallow #(.M_W(M_W), .A_W(A_W)) u_swallow (
    .clk      (clk_pre),
    .rst_n    (rst_n),
    .m_in     (m_val),
    .a_in     (a_val),
    .carry    (frac_carry),
    .mod_sel  (mod_sel),
    .boundary (cyc_end)
  );

  assign div_out = cyc_end;

  always_comb begin
    cfg_err = (m_val == '0) || (M_W'(a_val) > m_val) ||
              ((M_W'(a_val) == m_val) && (f_val != '0));
  end

  assert_carry_fits_R4: assert property (@(posedge clk_pre) disable iff (!rst_n)
    (cyc_end && !cfg_err) |=> !(frac_carry && (M_W'(a_val) == m_val) && $stable(a_val) && $stable(m_val)));
endmodule

// File: tb/tb_fnd_divider_ctrl.sv
module tb_fnd_divider_ctrl;
  localparam int CLK_T = 10;
  localparam int P     = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] m_val = 9'd4;
  logic [4:0] a_val = 5'd1;
  logic [4:0] f_val = 5'd0;
  logic       mod_sel, div_out, cfg_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  int exp_m = 1, exp_a = 0, exp_c = 0, exp_f = 0;
  bit exp_clr = 1;
  int acc = 0, prev_f = 0;
  int pulses = 0, high = 0, vco = 0;
  bit seen_low = 0, rise_err = 0;
  int run_n = 0, run_sum = 0;
  int nb = 0;

  always #(CLK_T/2) clk = ~clk;

  fnd_divider_ctrl dut (
    .clk_pre (clk), .rst_n (rst_n), .m_val (m_val), .a_val (a_val),
    .f_val (f_val), .mod_sel (mod_sel), .div_out (div_out), .cfg_err (cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // expected carry: modulo-32 accumulation
  function automatic int next_acc(input int a, input int f);
    return (a + f) % 32;
  endfunction
  function automatic int carry_of(input int a, input int f);
    return ((a + f) >= 32) ? 1 : 0;
  endfunction

  task automatic sample();
    int meas_c;
    pulses++;
    vco += mod_sel ? P + 1 : P;
    if (mod_sel) begin
      high++;
      if (seen_low) rise_err = 1;
    end else begin
      seen_low = 1;
    end
    if (div_out) begin
      meas_c = vco - P * exp_m - exp_a;
      chk(pulses == exp_m, "R2 pulses per cycle", pulses, exp_m);
      chk(!rise_err, "R3 mod_sel rose mid-cycle", rise_err, 0);
      chk(high == exp_a + exp_c, "R3 high count", high, exp_a + exp_c);
      chk(vco == P * exp_m + exp_a + exp_c, "R4 R7 cycle length", vco, P * exp_m + exp_a + exp_c);
      chk(meas_c == exp_c, "R5 R8 carry", meas_c, exp_c);
      if (!exp_clr) begin
        run_n++;
        run_sum += meas_c;
        if (run_n == 32) begin
          chk(run_sum == exp_f, "R6 carries per 32 cycles", run_sum, exp_f);
          run_n = 0;
          run_sum = 0;
        end
      end
      // next cycle's expectation from inputs held now
      if (f_val == 0 || int'(f_val) != prev_f) begin
        acc = 0; exp_c = 0; exp_clr = 1; run_n = 0; run_sum = 0;
      end else begin
        exp_c = carry_of(acc, f_val);
        acc = next_acc(acc, f_val);
        exp_clr = 0;
      end
      prev_f = f_val;
      exp_f = f_val;
      exp_m = m_val;
      exp_a = a_val;
      pulses = 0; high = 0; vco = 0; seen_low = 0; rise_err = 0;
      nb++;
    end
  endtask

  // inputs are applied one time unit after a rising edge, sampled on falling edges
  task automatic run_seg(input int m, input int a, input int f, input int ncyc, input int skew);
    int start;
    for (int k = 0; k < skew; k++) begin
      @(negedge clk); sample();
      @(posedge clk); #1;
    end
    m_val = 9'(m); a_val = 5'(a); f_val = 5'(f);
    start = nb;
    while (nb - start < ncyc) begin
      @(negedge clk); sample();
      @(posedge clk); #1;
    end
  endtask

  task automatic err_case(input int m, input int a, input int f, input int e);
    m_val = 9'(m); a_val = 5'(a); f_val = 5'(f);
    #1;
    chk(cfg_err == e[0], "R9 cfg_err", cfg_err, e);
  endtask

  initial begin
    void'($urandom(32'd4711));
    // R9 under reset: illegal words are never loaded
    err_case(3, 4, 0, 1);
    err_case(3, 3, 0, 0);
    err_case(3, 3, 5, 1);
    err_case(0, 0, 0, 1);
    err_case(3, 2, 5, 0);
    err_case(20, 19, 31, 0);
    m_val = 9'd4; a_val = 5'd1; f_val = 5'd0;
    #2;
    chk(div_out == 1'b1 && mod_sel == 1'b0, "R1 reset outputs", {div_out, mod_sel}, 2);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(div_out == 1'b1 && mod_sel == 1'b0, "R1 first clock", {div_out, mod_sel}, 2);
    sample();
    @(posedge clk); #1;
    // directed corners
    run_seg(4, 1, 0, 4, 0);
    run_seg(3, 1, 12, 40, 1);
    run_seg(5, 4, 16, 40, 2);
    run_seg(7, 0, 31, 40, 3);
    run_seg(6, 6, 0, 6, 1);
    run_seg(1, 0, 0, 5, 0);
    run_seg(9, 2, 12, 40, 4);
    run_seg(9, 3, 12, 40, 5);
    run_seg(4, 3, 8, 40, 2);
    run_seg(4, 3, 0, 5, 1);
    run_seg(10, 9, 1, 40, 7);
    // random segments
    for (int s = 0; s < 24; s++) begin
      int m, a, f;
      m = 2 + int'($urandom % 19);
      a = int'($urandom % m);
      if (a > 31) a = 31;
      f = int'($urandom % 32);
      if (s % 4 == 0) f = f & 5'h1c;
      run_seg(m, a, f, 34 + int'($urandom % 8), int'($urandom % m));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule